// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable model of a small serial EEPROM that stores 16-bit words. A host talks to it over four signals: a chip select, a serial clock, a serial data input and a serial data output. A parameter sets the address width to 6 bits (64 words) or 8 bits (256 words). The host raises chip select and clocks in a frame. The frame holds a start bit, a 2-bit opcode, the address and, for the two write commands, a 16-bit data word. The host then reads the reply on the data output.

The model decodes a read, a single-word write, a single-word erase, and four special commands. The special commands set and clear a write-enable latch, erase every word, and write one word to every location. Each programming command loads a busy timer that counts a parameter number of system clock cycles. While a following select is held, the data output reports whether the timer is still running. All inputs are treated as synchronous to the system clock `clk`. The model detects serial clock edges by oversampling the serial clock with `clk`. The storage is a plain register array that reset does not clear.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the write-enable latch is clear and the device waits for a start bit. `dout` is 0 whenever `cs` is low. Before any programming command has run, `dout` is also 0 while `cs` is high and the device is idle.
- R2: Data in is sampled on each rising edge of `sk` while `cs` is high. Zeros before the first 1 are ignored, and that first 1 is the start bit. The opcode follows the start bit, MSB first: 10 is read, 01 is write, 11 is erase, and 00 selects a special command.
- R3: For a read, `dout` is 0 right after the edge that samples the last address bit. Each of the next 16 rising edges of `sk` then puts out one bit of the addressed word, MSB first.
- R4: A write takes 16 data bits, MSB first, after the address and stores them at the address. The other words keep their contents.
- R5: Write, erase, erase-all and write-all change nothing while the write-enable latch is clear.
- R6: In a special command, the two address MSBs select the operation. 11 sets the write-enable latch and 00 clears it. The remaining address bits are ignored.
- R7: An erase sets the addressed word to 0xFFFF.
- R8: Special sub-code 10 sets every word to 0xFFFF. Sub-code 01 reads 16 data bits and writes that word to every location.
- R9: After a programming command, `cs` is dropped and raised again. `dout` is then 0 for up to BUSY_CYCLES clock cycles after the command's last bit, and 1 after that.
- R10: Dropping `cs` part-way through a frame abandons the command without any effect. The device is then ready for a new start bit.
- R11: While the busy timer runs, start bits are ignored. The device stays idle and keeps reporting the busy status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; it samples the serial inputs and runs the busy timer |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock; data in is sampled on its rising edge |
| di | input | 1 | Serial data in |
| dout | output | 1 | Serial data out: read bits or busy/ready status |

## Verification
The hardest case to reach is a start bit that arrives while a programming operation is still busy. The host has to start a new frame within the busy window, which only a short command right after a write can do. The stimulus sends a complete read frame straight after a write, holds select until the timer has expired, and checks that the output shows ready rather than read data. A later normal read then confirms that the written word is intact. Aborted frames are produced by dropping select halfway through a write's data field and reading the target word back afterwards.

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int ADDR_W      = 6,
  parameter int WORD_W      = 16,
  parameter int BUSY_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic dout
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HDR_W = ADDR_W + 2;
  localparam int CNT_W = $clog2(WORD_W + HDR_W + 1);
  localparam int BSY_W = $clog2(BUSY_CYCLES + 1);

  localparam logic [2:0] S_IDLE = 3'd0;
  localparam logic [2:0] S_HDR  = 3'd1;
  localparam logic [2:0] S_DATA = 3'd2;
  localparam logic [2:0] S_READ = 3'd3;
  localparam logic [2:0] S_DONE = 3'd4;

  logic [2:0]        st;
  logic              sk_q;
  logic [CNT_W-1:0]  cnt;
  logic [HDR_W-1:0]  hdr;
  logic [WORD_W-1:0] wdat;
  logic [WORD_W:0]   rd_sh;
  logic              wen;
  logic              show_st;
  logic [BSY_W-1:0]  busy_cnt;
  logic [WORD_W-1:0] mem [DEPTH];

  wire edge_in = cs & sk & ~sk_q;
  wire busy    = busy_cnt != '0;

  wire [HDR_W-1:0]  hdr_nx  = {hdr[HDR_W-2:0], di};
  wire [1:0]        nx_op   = hdr_nx[HDR_W-1:HDR_W-2];
  wire [1:0]        nx_sub  = hdr_nx[ADDR_W-1:ADDR_W-2];
  wire [ADDR_W-1:0] nx_addr = hdr_nx[ADDR_W-1:0];
  wire [1:0]        cur_op  = hdr[HDR_W-1:HDR_W-2];
  wire [ADDR_W-1:0] cur_addr = hdr[ADDR_W-1:0];
  wire [WORD_W-1:0] wr_data = {wdat[WORD_W-2:0], di};

  wire hdr_last = edge_in && st == S_HDR  && cnt == CNT_W'(HDR_W - 1);
  wire dat_last = edge_in && st == S_DATA && cnt == CNT_W'(WORD_W - 1);

  wire do_erase = wen && hdr_last && nx_op == 2'b11;
  wire do_eral  = wen && hdr_last && nx_op == 2'b00 && nx_sub == 2'b10;
  wire do_write = wen && dat_last && cur_op == 2'b01;
  wire do_wral  = wen && dat_last && cur_op == 2'b00;
  wire wr_all   = do_eral | do_wral;
  wire wr_one   = do_erase | do_write;
  wire prog     = wr_all | wr_one;

  wire [ADDR_W-1:0] wr_adr = do_erase ? nx_addr : cur_addr;
  wire [WORD_W-1:0] wr_val = (do_erase | do_eral) ? '1 : wr_data;

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++)
      if (wr_all || (wr_one && wr_adr == ADDR_W'(i)))
        mem[i] <= wr_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sk_q     <= 1'b0;
      cnt      <= '0;
      hdr      <= '0;
      wdat     <= '0;
      rd_sh    <= '0;
      wen      <= 1'b0;
      show_st  <= 1'b0;
      busy_cnt <= '0;
    end else begin
      sk_q <= sk;
      if (prog) begin
        busy_cnt <= BSY_W'(BUSY_CYCLES);
        show_st  <= 1'b1;
      end else if (busy) begin
        busy_cnt <= busy_cnt - BSY_W'(1);
      end
      if (!cs) begin
        st  <= S_IDLE;
        cnt <= '0;
      end else if (edge_in) begin
        case (st)
          S_IDLE:
            if (di && !busy) begin
              st      <= S_HDR;
              cnt     <= '0;
              show_st <= 1'b0;
            end
          S_HDR: begin
            hdr <= hdr_nx;
            cnt <= cnt + CNT_W'(1);
            if (hdr_last) begin
              cnt <= '0;
              case (nx_op)
                2'b10: begin
                  st    <= S_READ;
                  rd_sh <= {1'b0, mem[nx_addr]};
                end
                2'b01: st <= S_DATA;
                2'b11: st <= S_DONE;
                default:
                  case (nx_sub)
                    2'b11: begin wen <= 1'b1; st <= S_DONE; end
                    2'b00: begin wen <= 1'b0; st <= S_DONE; end
                    2'b01: st <= S_DATA;
                    default: st <= S_DONE;
                  endcase
              endcase
            end
          end
          S_DATA: begin
            wdat <= wr_data;
            cnt  <= cnt + CNT_W'(1);
            if (dat_last) st <= S_DONE;
          end
          S_READ: rd_sh <= {rd_sh[WORD_W-1:0], 1'b0};
          default: ;
        endcase
      end
    end
  end

  assign dout = cs & ((st == S_READ & rd_sh[WORD_W]) |
                      (st == S_IDLE & show_st & ~busy));
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk #(
  parameter int BSY_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs,
  input logic             dout,
  input logic             edge_in,
  input logic             wen,
  input logic [2:0]       st,
  input logic [BSY_W-1:0] busy_cnt
);
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (!wen && st == 3'd0));

  a_r1_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> !dout);

  a_r3_dummy_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd3 && $past(st) != 3'd3) |-> !dout);

  a_r5_locked_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!wen && busy_cnt == '0) |=> busy_cnt == '0);

  a_r9_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && st == 3'd0 && busy_cnt != '0) |-> !dout);

  a_r11_start_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_cnt != '0 && st == 3'd0 && edge_in) |=> st == 3'd0);
endmodule

bind mw_eeprom mw_eeprom_chk #(.BSY_W(BSY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .dout(dout), .edge_in(edge_in),
  .wen(wen), .st(st), .busy_cnt(busy_cnt)
);

// File: tb/mw_eeprom_test.sv
module mw_eeprom_test;
  localparam int AW   = 6;
  localparam int BUSY = 80;

  logic clk = 1'b0;
  logic rst_n, cs, sk, di;
  logic dout;
  int checks = 0;
  int errors = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] cap;
  event        cap_ev;

  always #10 clk = ~clk;

  mw_eeprom #(.ADDR_W(AW), .WORD_W(16), .BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .dout(dout)
  );

  task automatic chk(input bit ok, input string r, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic clk_bit(input logic b, output logic o);
    @(negedge clk); di = b; sk = 1'b0;
    repeat (2) @(negedge clk);
    sk = 1'b1;
    repeat (2) @(negedge clk);
    o = dout;
  endtask

  task automatic select();
    @(negedge clk); cs = 1'b1;
    @(negedge clk);
  endtask

  task automatic deselect();
    @(negedge clk); sk = 1'b0; cs = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic settle();
    repeat (BUSY + 10) @(negedge clk);
  endtask

  task automatic send_hdr(input int lead, input logic [1:0] op, input logic [AW-1:0] a, output logic o);
    select();
    for (int i = 0; i < lead; i++) clk_bit(1'b0, o);
    clk_bit(1'b1, o);
    for (int i = 1; i >= 0; i--) clk_bit(op[i], o);
    for (int i = AW - 1; i >= 0; i--) clk_bit(a[i], o);
  endtask

  task automatic send_word(input logic [15:0] v);
    logic o;
    for (int i = 15; i >= 0; i--) clk_bit(v[i], o);
  endtask

  task automatic rd(input int lead, input logic [AW-1:0] a, input logic [15:0] exp, input string tag);
    logic o;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    send_hdr(lead, 2'b10, a, o);
    chk(o == 1'b0, "R3 dummy zero", {15'd0, o}, 16'h0);
    cap = '0;
    for (int i = 0; i < 16; i++) begin
      clk_bit(1'b0, o);
      cap = {cap[14:0], o};
    end
    -> cap_ev;
    deselect();
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] v);
    logic o;
    send_hdr(0, 2'b01, a, o);
    send_word(v);
    deselect();
  endtask

  task automatic special(input logic [1:0] sub);
    logic o;
    send_hdr(0, 2'b00, {sub, {(AW-2){1'b0}}}, o);
    deselect();
  endtask

  task automatic erase(input logic [AW-1:0] a);
    logic o;
    send_hdr(0, 2'b11, a, o);
    deselect();
  endtask

  task automatic wral(input logic [15:0] v);
    logic o;
    send_hdr(0, 2'b00, {2'b01, {(AW-2){1'b0}}}, o);
    send_word(v);
    deselect();
  endtask

  initial begin
    forever begin
      logic [15:0] e;
      string t;
      @(cap_ev);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(cap === e, t, cap, e);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic o;
    rst_n = 1'b0; cs = 1'b0; sk = 1'b0; di = 1'b0;
    repeat (5) @(negedge clk);
    chk(dout == 1'b0, "R1 dout low in reset", {15'd0, dout}, 16'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    select();
    repeat (3) @(negedge clk);
    chk(dout == 1'b0, "R1 no status before programming", {15'd0, dout}, 16'h0);
    deselect();

    // R6 enable, R8 erase-all, R9 status
    special(2'b11);
    {o} = 1'b0;
    send_hdr(0, 2'b00, {2'b10, {(AW-2){1'b0}}}, o);
    deselect();
    select();
    chk(dout == 1'b0, "R9 busy reads 0", {15'd0, dout}, 16'h0);
    repeat (BUSY + 5) @(negedge clk);
    chk(dout == 1'b1, "R9 ready reads 1", {15'd0, dout}, 16'h1);
    deselect();
    rd(0, 6'd5, 16'hFFFF, "R8 erase-all word 5");

    // R5 / R6: disabled write ignored
    special(2'b00);
    wr(6'd5, 16'h1234);
    settle();
    rd(0, 6'd5, 16'hFFFF, "R5 write while locked");

    // R4 writes
    special(2'b11);
    wr(6'd5, 16'h1234);  settle();
    wr(6'd63, 16'hBEEF); settle();
    wr(6'd0, 16'h0001);  settle();
    rd(0, 6'd5,  16'h1234, "R4 word 5");
    rd(0, 6'd63, 16'hBEEF, "R4 top word");
    rd(0, 6'd0,  16'h0001, "R4 bottom word");

    // R7 erase
    erase(6'd5); settle();
    rd(0, 6'd5,  16'hFFFF, "R7 erase word 5");
    rd(0, 6'd63, 16'hBEEF, "R7 neighbour kept");

    // R8 write-all
    wral(16'h5A3C); settle();
    rd(0, 6'd0,  16'h5A3C, "R8 write-all word 0");
    rd(0, 6'd63, 16'h5A3C, "R8 write-all word 63");
    rd(0, 6'd17, 16'h5A3C, "R8 write-all word 17");

    // R11 start bit while busy
    wr(6'd9, 16'h0F0F);
    send_hdr(0, 2'b10, 6'd9, o);
    repeat (BUSY + 10) @(negedge clk);
    chk(dout == 1'b1, "R11 read during busy ignored", {15'd0, dout}, 16'h1);
    deselect();
    rd(0, 6'd9, 16'h0F0F, "R11 word written before blocked read");

    // R6 disable then R5 erase/write-all ignored
    special(2'b00);
    erase(6'd17); settle();
    rd(0, 6'd17, 16'h5A3C, "R6 erase after disable");
    wral(16'h0000); settle();
    rd(0, 6'd0, 16'h5A3C, "R5 write-all while locked");

    // R2 leading zeros
    rd(3, 6'd17, 16'h5A3C, "R2 leading zeros");

    // R10 aborted frame
    special(2'b11);
    send_hdr(0, 2'b01, 6'd17, o);
    for (int i = 0; i < 8; i++) clk_bit(1'b0, o);
    deselect();
    settle();
    rd(0, 6'd17, 16'h5A3C, "R10 aborted write");

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule